// File: doc/BRIEF.md
# Triggered Echo Capture Sequencer

This block brings up a high-speed sampling path in a fixed order, records one burst of digitized samples, and then searches the record for a pulse echo. After reset it first asks an external clock synthesizer to configure itself, using a start/done handshake. Only after that does it request a reset of the deserializer's phase alignment, using a request/acknowledge pair. Once alignment is back, the block waits for a capture trigger.

On the trigger it writes a full record of sample words into an internal dual-port memory at consecutive addresses. Each word holds two signed 16-bit channels. The record is then read back through the second port at a quarter of the capture rate, using a clock enable on the same clock. The block averages the magnitudes of the first sixteen words, adds a programmable offset to form a threshold, and reports the index of the first later word whose magnitude is above that threshold. If no word is above it, the block reports that there is no echo.

After each result the block goes back to waiting for a trigger. It does not configure the synthesizer or reset the alignment again.

Top module: `echo_capture_seq`

## Requirements
- R1: After reset `cfg_start` is high, and `align_req` and `echo_valid` are low. Nothing else happens until `cfg_done` is seen.
- R2: `align_req` rises only in the cycle after `cfg_done` is sampled high, at which point `cfg_start` drops. `align_req` stays high until `align_ack` is sampled high.
- R3: The block ignores a trigger that arrives before alignment completes. Sample words presented before the accepted trigger are not part of the record.
- R4: The word present at the accepted trigger edge is record word 0. The words on the following DEPTH-1 edges become words 1 to DEPTH-1, written at incrementing addresses.
- R5: Both channels are stored. Channel A is bits [15:0] and channel B is bits [31:16], both two's complement. The magnitude of a word is |A| + |B|.
- R6: Readback takes one word every 4 clock cycles. `echo_valid` is high exactly in the cycle that starts 5*DEPTH-3 rising edges after the trigger edge.
- R7: The threshold is floor(sum of the magnitudes of words 0..15 / 16) + `thr_offset`.
- R8: `echo_idx` is the lowest index of 16 or above whose magnitude is strictly greater than the threshold. A word equal to the threshold does not count, and words 0..15 never count.
- R9: If no word meets R8, `no_echo` is 1 and `echo_idx` is 0 while `echo_valid` is high. Otherwise `no_echo` is 0.
- R10: The block ignores triggers during capture, readback and the result cycle. The reported result belongs to the first record.
- R11: `echo_valid` is a single-cycle pulse. Afterwards the block waits for a new trigger, and `cfg_start` and `align_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for capture and readback |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | output | 1 | Requests synthesizer configuration |
| cfg_done | input | 1 | Synthesizer configuration finished |
| align_req | output | 1 | Requests deserializer alignment reset |
| align_ack | input | 1 | Alignment restored |
| trig | input | 1 | Capture trigger |
| sample_in | input | 32 | Two interleaved signed 16-bit channels |
| thr_offset | input | 16 | Unsigned offset added to the window mean |
| echo_valid | output | 1 | One-cycle result strobe |
| no_echo | output | 1 | No word exceeded the threshold |
| echo_idx | output | 8 | Record index of the detected echo |

## Verification
The assertions assume that `cfg_done` and `align_ack` only matter while their matching request is high. They also assume that `thr_offset` stays constant during a readback, since the threshold is latched from it once the window ends.

The stimulus drives every input half a cycle away from the clock edge. It changes the offset only between records. It pulses `trig` at illegal times on purpose: during bring-up, throughout capture and throughout readback. It also places loud words just before each trigger, so that any leak into the record would show up in the result.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [2:0] {
    ST_CFG   = 3'd0,
    ST_ALIGN = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CAPT  = 3'd3,
    ST_READ  = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/echo_dpram.sv
module echo_dpram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/echo_rate_div.sv
module echo_rate_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic en
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign en = run && (cnt == '0);

  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en); // R6
endmodule

// File: rtl/echo_search.sv
module echo_search #(
  parameter int CH_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int WIN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pv,
  input  logic [ADDR_W-1:0] pidx,
  input  logic [2*CH_W-1:0] pdata,
  input  logic [CH_W-1:0]   offset,
  output logic              found,
  output logic [ADDR_W-1:0] hit_idx
);
  localparam int MAG_W = CH_W + 2;
  localparam int SUM_W = MAG_W + WIN_LOG2;
  localparam int THR_W = MAG_W + 1;
  localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'((1 << WIN_LOG2) - 1);

  function automatic logic [CH_W:0] abs_ch(input logic [CH_W-1:0] x);
    logic [CH_W:0] e;
    e = {x[CH_W-1], x};
    return x[CH_W-1] ? (~e + (CH_W+1)'(1)) : e;
  endfunction

  function automatic logic [MAG_W-1:0] mag_of(input logic [2*CH_W-1:0] w);
    return MAG_W'(abs_ch(w[CH_W-1:0])) + MAG_W'(abs_ch(w[2*CH_W-1:CH_W]));
  endfunction

  function automatic logic [THR_W-1:0] thr_of(input logic [SUM_W-1:0] s,
                                               input logic [CH_W-1:0] o);
    return THR_W'(s >> WIN_LOG2) + THR_W'(o);
  endfunction

  logic [MAG_W-1:0] mag;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_next;
  logic [THR_W-1:0] thr;
  logic             in_win;
  logic             over;

  assign mag      = mag_of(pdata);
  assign in_win   = (pidx <= WIN_LAST);
  assign sum_next = (pidx == '0) ? SUM_W'(mag) : sum + SUM_W'(mag);
  assign over     = THR_W'(mag) > thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum     <= '0;
      thr     <= '0;
      found   <= 1'b0;
      hit_idx <= '0;
    end else if (pv) begin
      if (in_win) begin
        sum <= sum_next;
        if (pidx == '0) begin
          found   <= 1'b0;
          hit_idx <= '0;
        end
        if (pidx == WIN_LAST) thr <= thr_of(sum_next, offset);
      end else if (!found && over) begin
        found   <= 1'b1;
        hit_idx <= pidx;
      end
    end
  end

  AST_HIT_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (hit_idx > WIN_LAST)); // R8
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (found && pv && !in_win) |=> (found && $stable(hit_idx))); // R8
endmodule

// File: rtl/echo_capture_seq.sv
module echo_capture_seq
  import echo_pkg::*;
#(
  parameter int CH_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int WIN_LOG2 = 4,
  parameter int RD_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cfg_start,
  input  logic              cfg_done,
  output logic              align_req,
  input  logic              align_ack,
  input  logic              trig,
  input  logic [2*CH_W-1:0] sample_in,
  input  logic [CH_W-1:0]   thr_offset,
  output logic              echo_valid,
  output logic              no_echo,
  output logic [ADDR_W-1:0] echo_idx
);
  localparam int DATA_W = 2 * CH_W;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  seq_state_t        state;
  logic [ADDR_W-1:0] wcnt;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W-1:0] pidx;
  logic              pv;
  logic              mem_we;
  logic [ADDR_W-1:0] waddr;
  logic              rd_en;
  logic              rd_run;
  logic [DATA_W-1:0] rdata;
  logic              found;
  logic [ADDR_W-1:0] hit_idx;
  logic              take_trig;

  assign take_trig = (state == ST_WAIT) && trig;
  assign mem_we    = take_trig || (state == ST_CAPT);
  assign waddr     = (state == ST_CAPT) ? wcnt : '0;
  assign rd_run    = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_CFG;
      wcnt  <= '0;
      raddr <= '0;
      pv    <= 1'b0;
      pidx  <= '0;
    end else begin
      pv <= rd_en;
      if (rd_en) pidx <= raddr;
      unique case (state)
        ST_CFG:   if (cfg_done) state <= ST_ALIGN;
        ST_ALIGN: if (align_ack) state <= ST_WAIT;
        ST_WAIT: if (trig) begin
          state <= ST_CAPT;
          wcnt  <= ADDR_W'(1);
        end
        ST_CAPT: if (wcnt == LAST) begin
          state <= ST_READ;
          raddr <= '0;
        end else begin
          wcnt <= wcnt + ADDR_W'(1);
        end
        ST_READ: begin
          if (rd_en) raddr <= raddr + ADDR_W'(1);
          if (pv && pidx == LAST) state <= ST_DONE;
        end
        ST_DONE:  state <= ST_WAIT;
        default:  state <= ST_CFG;
      endcase
    end
  end

  echo_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(sample_in),
    .re(rd_en), .raddr(raddr), .rdata(rdata)
  );

  echo_rate_div #(.DIV(RD_DIV)) i_div (
    .clk(clk), .rst_n(rst_n), .run(rd_run), .en(rd_en)
  );

  echo_search #(.CH_W(CH_W), .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) i_search (
    .clk(clk), .rst_n(rst_n), .pv(pv), .pidx(pidx), .pdata(rdata),
    .offset(thr_offset), .found(found), .hit_idx(hit_idx)
  );

  assign cfg_start  = (state == ST_CFG);
  assign align_req  = (state == ST_ALIGN);
  assign echo_valid = (state == ST_DONE);
  assign no_echo    = !found;
  assign echo_idx   = found ? hit_idx : '0;

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |-> (!align_req && !mem_we && !echo_valid)); // R1
  AST_ALIGN_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_req) |-> $past(cfg_done)); // R2
  AST_ALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (align_req && !align_ack) |=> align_req); // R2
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> ((waddr - $past(waddr)) == ADDR_W'(1))); // R4
  AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !mem_we); // R10
  AST_NOECHO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_valid && no_echo) |-> (echo_idx == '0)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    echo_valid |=> (!echo_valid && !cfg_start && !align_req)); // R11
endmodule

// File: tb/test_echo_capture_seq.sv
module test_echo_capture_seq;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_done = 1'b0;
  logic        align_ack = 1'b0;
  logic        trig = 1'b0;
  logic [31:0] sample_in = '0;
  logic [15:0] thr_offset = '0;
  logic        cfg_start, align_req, echo_valid, no_echo;
  logic [7:0]  echo_idx;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_valid = 0;
  bit done_flag = 0;
  logic [31:0] rec [DEPTH];

  always #5 clk = ~clk;

  echo_capture_seq i_echo_capture_seq (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_done(cfg_done),
    .align_req(align_req), .align_ack(align_ack), .trig(trig),
    .sample_in(sample_in), .thr_offset(thr_offset), .echo_valid(echo_valid),
    .no_echo(no_echo), .echo_idx(echo_idx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (echo_valid) n_valid <= n_valid + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  function automatic int mag(input logic [31:0] w);
    int a, b;
    a = int'($signed(w[15:0]));
    b = int'($signed(w[31:16]));
    return (a < 0 ? -a : a) + (b < 0 ? -b : b);
  endfunction

  function automatic int thr_exp(input int off);
    int s = 0;
    for (int k = 0; k < 16; k++) s += mag(rec[k]);
    return s / 16 + off;
  endfunction

  function automatic int hit_exp(input int off);
    int t = thr_exp(off);
    for (int k = 16; k < DEPTH; k++) if (mag(rec[k]) > t) return k;
    return -1;
  endfunction

  task automatic build(input int pos, input int amp, input int seed, input bit negb);
    for (int k = 0; k < DEPTH; k++) begin
      int a, b;
      a = ((k * seed + 3) % 9) - 4;
      b = ((k * 5 + seed) % 7) - 3;
      if (k == pos) begin
        a = amp;
        b = negb ? -amp : 0;
      end
      rec[k] = {16'(b), 16'(a)};
    end
  endtask

  task automatic run_case(input string nm, input int off, input bit hold_trig,
                          input bit retrig, input int exp_req);
    int cur, hit, lat;
    thr_offset = 16'(off);
    @(negedge clk);
    sample_in = 32'h7FFF_8001;
    trig = 1'b0;
    @(negedge clk);
    cur = cyc;
    trig = 1'b1;
    sample_in = rec[0];
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge clk);
      sample_in = rec[k];
      trig = hold_trig;
    end
    @(negedge clk);
    sample_in = 32'h7FFF_7FFF;
    trig = retrig;
    while (!echo_valid) @(negedge clk);
    trig = 1'b0;
    lat = cyc - cur;
    hit = hit_exp(off);
    chk(lat == 5 * DEPTH - 2, "R6 latency", lat, 5 * DEPTH - 2);
    if (hit < 0) begin
      chk(no_echo == 1'b1, {"R9 no_echo ", nm}, int'(no_echo), 1);
      chk(echo_idx == 8'd0, {"R9 idx ", nm}, int'(echo_idx), 0);
    end else begin
      chk(no_echo == 1'b0, {"R8 no_echo ", nm}, int'(no_echo), 0);
      chk(int'(echo_idx) == hit, {"R8 idx ", nm}, int'(echo_idx), hit);
    end
    chk((hit < 0) == (exp_req < 0), {"R7 case intent ", nm}, hit, exp_req);
    @(negedge clk);
    chk(!echo_valid && !cfg_start && !align_req, "R11 pulse/no re-bringup",
        int'({echo_valid, cfg_start, align_req}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_start == 1'b1, "R1 cfg_start after reset", int'(cfg_start), 1);
    chk(align_req == 1'b0, "R1 align_req after reset", int'(align_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    trig = 1'b1;
    sample_in = 32'h0100_0100;
    repeat (20) @(negedge clk);
    chk(cfg_start && !align_req, "R1 waits for cfg_done",
        int'({cfg_start, align_req}), 2);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    chk(align_req && !cfg_start, "R2 align after cfg_done",
        int'({cfg_start, align_req}), 1);
    repeat (10) @(negedge clk);
    chk(align_req == 1'b1, "R2 align held until ack", int'(align_req), 1);
    trig = 1'b0;
    align_ack = 1'b1;
    @(negedge clk);
    align_ack = 1'b0;
    chk(align_req == 1'b0, "R2 align dropped on ack", int'(align_req), 0);
    repeat (1400) @(negedge clk);
    chk(n_valid == 0, "R3 early trigger ignored", n_valid, 0);

    build(16, 300, 2, 0);
    run_case("R8 echo at 16", 10, 0, 0, 16);
    build(255, 200, 3, 0);
    run_case("R8 echo at last", 10, 0, 0, 255);
    build(100, -120, 4, 1);
    run_case("R5 negative both channels", 50, 0, 0, 100);
    build(7, 30000, 5, 0);
    run_case("R8 loud in window", 8, 0, 0, -1);
    build(-1, 0, 6, 0);
    run_case("R9 flat record", 20, 0, 0, -1);
    build(-1, 0, 7, 0);
    rec[40] = {16'd0, 16'(thr_exp(20))};
    run_case("R8 equal not over", 20, 0, 0, -1);
    build(60, 40, 2, 0);
    rec[61] = {16'd0, 16'd500};
    run_case("R10 trig held in capture", 5, 1, 0, 60);
    build(200, 80, 3, 1);
    run_case("R10 trig during readback", 5, 0, 1, 200);
    build(-1, 0, 8, 0);
    rec[20] = {16'h8000, 16'h8000};
    run_case("R5 extreme negative", 0, 0, 0, 20);
    for (int p = 17; p < DEPTH; p += 29) begin
      build(p, 64, p % 9 + 1, p[0]);
      run_case("R4 position sweep", 30, 0, 0, p);
    end
    chk(n_valid == 18, "R11 one pulse per record", n_valid, 18);
    finish_run();
  end
endmodule